// File: doc/BRIEF.md
# Eight-level priority interrupt controller

This block collects eight level-sensitive interrupt request lines, passes each through a two-flop synchroniser and then picks one winner among the requests that are not masked. It raises a single interrupt line to the processor whenever a request is allowed through. It also shows the number of the level that would be served next. Software reaches the block through a small 8-bit register port. The port holds a mask, a 3-bit lowest-priority level that rotates the priority order, an in-service view and a vector register. Writing a level number to the end-of-interrupt address clears that level.

When the processor pulses the acknowledge input while the interrupt line is high, the block latches the winning level into the vector register and marks that level in service. While a level is in service, requests of equal or lower priority are held off, and higher ones still get through. After reset the order is fixed with level 7 highest and level 0 lowest. The package names the usual source on each level: the floppy controller on level 0, then small peripherals, serial, the instrument bus, the card slot, the real-time clock and the main board on level 6. Level 7 is left spare.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask, the lowest-level register, the in-service register and the vector register all read 0, and irq_o is low.
- R2: A change on req_i reaches irq_o and win_level_o after exactly two rising clock edges, through two synchronising flops.
- R3: irq_o is high exactly when at least one synchronised request is unmasked and outranks every in-service level. When irq_o is high, win_level_o is the highest-priority such level.
- R4: Mask register (address 0): a 1 in bit n stops level n from raising irq_o or winning.
- R5: With the lowest-level register at 0, level 7 has the highest priority and level 0 the lowest.
- R6: Lowest-level register (address 1, bits 2:0) holds a value b. Priority then descends through levels (b+7) mod 8, (b+6) mod 8, … down to b, so level (b+7) mod 8 is served first and b is served last.
- R7: ack_i sampled high while irq_o is high latches win_level_o into the vector register (read at address 3, bits 2:0) and sets that level's bit in the in-service register (read at address 2).
- R8: While any in-service bit is set, a request is allowed only if its priority is strictly above that of every in-service level.
- R9: A write to address 2 clears the in-service bit whose number is in wdata bits 2:0.
- R10: ack_i sampled while irq_o is low has no effect: the in-service and vector registers keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Level-sensitive interrupt requests, bit n for level n |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 mask, 1 lowest level, 2 end-of-interrupt / in-service, 3 vector) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr, combinational |
| ack_i | input | 1 | Interrupt acknowledge from the processor |
| irq_o | output | 1 | Interrupt request to the processor |
| win_level_o | output | 3 | Level that would be served by the next acknowledge |

## Verification
All 256 request patterns are tried first with the default order and then under each of the eight lowest-level settings. This separates a correct rotation from one that is shifted by a level or runs in the wrong direction. All 256 masks are applied against a full set of requests, which shows whether masking removes exactly the masked levels from the search. A nested acknowledge sequence checks the hold-off at equal, lower and higher priority, the end-of-interrupt release, and an acknowledge given while no request is pending.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int NUM_LEVELS = 8;
  localparam int LVL_W      = $clog2(NUM_LEVELS);
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 2;

  typedef logic [LVL_W-1:0]      level_t;
  typedef logic [NUM_LEVELS-1:0] vec_t;

  localparam logic [ADDR_W-1:0] ADDR_MASK = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_BASE = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_EOI  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_VEC  = 2'd3;

  // Usual source placement on the levels
  localparam level_t SRC_FLOPPY  = 3'd0;
  localparam level_t SRC_SMALLPH = 3'd1;
  localparam level_t SRC_SERIAL  = 3'd2;
  localparam level_t SRC_INSTBUS = 3'd3;
  localparam level_t SRC_CARD    = 3'd4;
  localparam level_t SRC_RTC     = 3'd5;
  localparam level_t SRC_MAINBRD = 3'd6;
  localparam level_t SRC_SPARE   = 3'd7;

  // Rank of a level: 0 for the lowest-level register value, larger is higher
  function automatic level_t rank_of(level_t lvl, level_t base);
    return level_t'(lvl - base);
  endfunction

  function automatic vec_t onehot(level_t lvl);
    return vec_t'(1) << lvl;
  endfunction
endpackage

// File: rtl/prio_irq_sync.sv
module prio_irq_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int AGE_W = $clog2(STAGES + 1) + 1;

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else if (g == 0) stage_q[g] <= d_i;
        else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

  // Edges seen since reset, saturating, used to qualify the delay check
  logic [AGE_W-1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else if (age_q < AGE_W'(STAGES)) age_q <= age_q + 1'b1;
  end

  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= AGE_W'(STAGES)) |-> (q_o == $past(d_i, STAGES))); // R2
endmodule

// File: rtl/prio_irq_resolve.sv
module prio_irq_resolve
  import prio_irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  vec_t   pend_i,
  input  vec_t   mask_i,
  input  vec_t   isr_i,
  input  level_t base_i,
  output logic   irq_o,
  output level_t win_o
);
  vec_t   elig;
  logic   isr_any;
  level_t isr_top;
  logic   found;
  level_t best;

  always_comb begin
    isr_any = 1'b0;
    isr_top = '0;
    for (int l = 0; l < NUM_LEVELS; l++) begin
      if (isr_i[l]) begin
        if (!isr_any || rank_of(level_t'(l), base_i) > isr_top)
          isr_top = rank_of(level_t'(l), base_i);
        isr_any = 1'b1;
      end
    end
    for (int l = 0; l < NUM_LEVELS; l++)
      elig[l] = pend_i[l] & ~mask_i[l] &
                (~isr_any | (rank_of(level_t'(l), base_i) > isr_top));
    found = 1'b0;
    best  = '0;
    win_o = '0;
    for (int l = 0; l < NUM_LEVELS; l++) begin
      if (elig[l] && (!found || rank_of(level_t'(l), base_i) > best)) begin
        best  = rank_of(level_t'(l), base_i);
        win_o = level_t'(l);
        found = 1'b1;
      end
    end
  end

  assign irq_o = found;

  AST_WIN_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pend_i[win_o] && !mask_i[win_o])); // R4
  AST_WIN_NOT_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !isr_i[win_o]); // R8
  AST_IDLE_WHEN_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_i & ~mask_i) == '0) |-> !irq_o); // R3
endmodule

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
  import prio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ack_i,
  input  logic              irq_i,
  input  level_t            win_i,
  output vec_t              mask_o,
  output level_t            base_o,
  output vec_t              isr_o
);
  level_t vec_q;
  logic   take;
  logic   eoi_wr;
  level_t eoi_lvl;
  vec_t   isr_d;

  assign take    = ack_i & irq_i;
  assign eoi_wr  = we_i && (addr_i == ADDR_EOI);
  assign eoi_lvl = level_t'(wdata_i[LVL_W-1:0]);

  always_comb begin
    isr_d = isr_o;
    if (eoi_wr) isr_d = isr_d & ~onehot(eoi_lvl);
    if (take)   isr_d = isr_d | onehot(win_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o <= '0;
      base_o <= '0;
      isr_o  <= '0;
      vec_q  <= '0;
    end else begin
      isr_o <= isr_d;
      if (take) vec_q <= win_i;
      if (we_i && addr_i == ADDR_MASK) mask_o <= vec_t'(wdata_i);
      if (we_i && addr_i == ADDR_BASE) base_o <= level_t'(wdata_i[LVL_W-1:0]);
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_MASK: rdata_o = DATA_W'(mask_o);
      ADDR_BASE: rdata_o = DATA_W'(base_o);
      ADDR_EOI:  rdata_o = DATA_W'(isr_o);
      default:   rdata_o = DATA_W'(vec_q);
    endcase
  end

  AST_ACK_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (vec_q == $past(win_i)) && isr_o[$past(win_i)]); // R7
  AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && !(take && win_i == eoi_lvl)) |=> !isr_o[$past(eoi_lvl)]); // R9
  AST_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !irq_i && !eoi_wr) |=> ($stable(isr_o) && $stable(vec_q))); // R10
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  req_i,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        ack_i,
  output logic        irq_o,
  output logic [2:0]  win_level_o
);
  vec_t   pend_sync;
  vec_t   mask_r;
  vec_t   isr_r;
  level_t base_r;
  level_t win_w;
  logic   irq_w;

  prio_irq_sync #(.WIDTH(NUM_LEVELS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(req_i), .q_o(pend_sync)
  );

  prio_irq_resolve u_resolve (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_sync), .mask_i(mask_r),
    .isr_i(isr_r), .base_i(base_r), .irq_o(irq_w), .win_o(win_w)
  );

  prio_irq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(reg_we), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .rdata_o(reg_rdata), .ack_i(ack_i),
    .irq_i(irq_w), .win_i(win_w), .mask_o(mask_r), .base_o(base_r),
    .isr_o(isr_r)
  );

  assign irq_o       = irq_w;
  assign win_level_o = win_w;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !irq_o); // R1
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_i = '0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ack_i = 1'b0;
  logic       irq_o;
  logic [2:0] win_level_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ack_i(ack_i), .irq_o(irq_o), .win_level_o(win_level_o)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Walk from the top of the order downward; an in-service level ends the search
  task automatic model(input logic [7:0] rq, input logic [7:0] mk,
                       input logic [7:0] sv, input int base,
                       output bit hit, output int lvl);
    hit = 0; lvl = 0;
    for (int k = 0; k < 8; k++) begin
      int lv = (base + 7 - k) % 8;
      if (sv[lv]) break;
      if (rq[lv] && !mk[lv]) begin hit = 1; lvl = lv; break; end
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic set_req(input logic [7:0] v);
    @(negedge clk);
    req_i = v;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_ack();
    @(negedge clk);
    ack_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ack_i = 1'b0;
  endtask

  task automatic cmp(string req, logic [7:0] rq, logic [7:0] mk,
                     logic [7:0] sv, int base);
    bit h; int l;
    model(rq, mk, sv, base, h, l);
    check(req, int'(irq_o), int'(h));
    if (h) check(req, int'(win_level_o), l);
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      finish_sim();
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, d); check("R1 mask", d, 0);
    rd(2'd1, d); check("R1 base", d, 0);
    rd(2'd2, d); check("R1 isr", d, 0);
    rd(2'd3, d); check("R1 vec", d, 0);
    check("R1 irq", irq_o, 0);

    // R2 two-edge latency
    @(negedge clk); req_i = 8'h10;
    @(posedge clk); @(negedge clk);
    check("R2 after one edge", irq_o, 0);
    @(posedge clk); @(negedge clk);
    check("R2 after two edges", irq_o, 1);
    check("R2 winner", win_level_o, 4);
    set_req(8'h00);

    // R3 R5 all request patterns, default order
    for (int p = 0; p < 256; p++) begin
      set_req(8'(p));
      cmp("R3 R5 default order", 8'(p), 8'h00, 8'h00, 0);
    end

    // R6 every lowest-level setting over every pattern
    for (int b = 0; b < 8; b++) begin
      wr(2'd1, 8'(b));
      rd(2'd1, d); check("R6 base readback", d, b);
      for (int p = 0; p < 256; p++) begin
        set_req(8'(p));
        cmp("R6 rotated order", 8'(p), 8'h00, 8'h00, b);
      end
    end
    wr(2'd1, 8'd0);

    // R4 every mask with all levels requesting
    set_req(8'hFF);
    for (int m = 0; m < 256; m++) begin
      wr(2'd0, 8'(m));
      cmp("R4 mask", 8'hFF, 8'(m), 8'h00, 0);
    end
    rd(2'd0, d); check("R4 mask readback", d, 255);
    wr(2'd0, 8'h00);

    // R7 R8 R9 R10 nested service
    set_req(8'h28);
    check("R3 two pending", irq_o, 1);
    check("R3 two pending winner", win_level_o, 5);
    pulse_ack();
    rd(2'd3, d); check("R7 vector", d, 5);
    rd(2'd2, d); check("R7 isr", d, 8'h20);
    check("R8 lower held", irq_o, 0);
    pulse_ack();
    rd(2'd2, d); check("R10 isr unchanged", d, 8'h20);
    rd(2'd3, d); check("R10 vec unchanged", d, 5);
    set_req(8'hA8);
    check("R8 higher passes", irq_o, 1);
    check("R8 higher winner", win_level_o, 7);
    pulse_ack();
    rd(2'd3, d); check("R7 nested vector", d, 7);
    rd(2'd2, d); check("R7 nested isr", d, 8'hA0);
    cmp("R8 all held", 8'hA8, 8'h00, 8'hA0, 0);
    set_req(8'h28);
    wr(2'd2, 8'd7);
    rd(2'd2, d); check("R9 eoi top", d, 8'h20);
    check("R8 still held by level 5", irq_o, 0);
    wr(2'd2, 8'd5);
    rd(2'd2, d); check("R9 eoi last", d, 8'h00);
    check("R9 released", irq_o, 1);
    check("R9 released winner", win_level_o, 5);

    // R8 with rotation: base 5, level 4 in service blocks everything
    wr(2'd1, 8'd5);
    set_req(8'h10);
    pulse_ack();
    rd(2'd2, d); check("R7 rotated isr", d, 8'h10);
    set_req(8'hFF);
    cmp("R8 rotated top held", 8'hFF, 8'h00, 8'h10, 5);
    wr(2'd2, 8'd4);
    cmp("R9 rotated release", 8'hFF, 8'h00, 8'h00, 5);

    done = 1'b1;
    finish_sim();
  end
endmodule